// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns pairs of parallel 24-bit audio samples (one left, one right) into a two-channel serial bit stream. The bits go out MSB first on a single data line, framed by a bit clock and a word-select line. A frame is 64 bit clocks long and has two 32-bit slots: word select low is the left slot and high is the right slot. Each slot carries 24 data bits followed by zero padding. A static format input picks where the MSB sits relative to the word-select edge. With I2S timing it comes one bit clock after the edge. With MSB-justified timing it comes on the same bit clock as the edge.

A static mode input picks the clocking. In master mode the block divides its system clock (256 times the sample rate) by four to make the bit clock, and derives word select from it. In slave mode an external bit clock and word select are brought into the system-clock domain and followed. The data line changes only after a falling bit-clock edge, so a receiver samples it on the rising edge.

Samples enter through a valid/ready handshake into a one-deep holding register. At the start of each left slot the held pair moves into the output words. If no pair is waiting, the frame is sent as silence (all zeros). A pair accepted in the very cycle that a left slot starts bypasses the holding register and goes into that frame.

Top module: `ser_audio_tx`

## Requirements
- R1: While `rst` is high and after it falls until the first frame: `sdata` is 0, `smp_ready` is 1, `bck_out` is 0 and `ws_out` is 1.
- R2: With `master_mode`=1, `bck_out` is `clk` divided by 4: it stays low for 2 `clk` cycles, then high for 2.
- R3: With `master_mode`=1, `ws_out` changes only in the `clk` cycle in which `bck_out` falls. It stays at each level for 32 bit clocks: 0 marks the left slot and 1 the right slot.
- R4: With `master_mode`=1, `sdata` changes only in the `clk` cycle in which `bck_out` falls.
- R5: With `fmt_sel`=1 (MSB-justified), bit 23 of a slot's word is on `sdata` at the first rising bit-clock edge after word select changes. Bits 22 down to 0 follow on the next rising edges, then 8 zero bits.
- R6: With `fmt_sel`=0 (I2S), `sdata` is 0 at the first rising bit-clock edge of a slot. Bits 23 down to 0 follow on the next 24 rising edges, then 7 zero bits.
- R7: The encodings are: `fmt_sel` 0 = I2S and 1 = MSB-justified; `master_mode` 1 = master and 0 = slave. Every non-data position in a slot is 0.
- R8: With `master_mode`=0, framing follows `bck_in` and `ws_in`, passed through a 2-flop synchronizer. `sdata` settles no later than the third `clk` edge after a `bck_in` falling edge. `bck_out` is held at 0 and `ws_out` at 1.
- R9: `smp_ready` is 1 exactly when the holding register is empty. A pair is accepted when `smp_valid` and `smp_ready` are both high at a `clk` edge. After that `smp_ready` stays 0 until the next left-slot start.
- R10: The held pair is loaded at the falling bit-clock edge that starts a left slot. If no pair is held, that frame sends zeros in both slots.
- R11: A pair accepted in the same `clk` cycle as a left-slot load goes out in that frame, and `smp_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 fs in master mode) |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = generate bit clock and word select, 0 = follow inputs |
| fmt_sel | input | 1 | 0 = I2S timing, 1 = MSB-justified timing |
| smp_valid | input | 1 | A sample pair is offered |
| smp_left | input | 24 | Left-channel sample |
| smp_right | input | 24 | Right-channel sample |
| smp_ready | output | 1 | Holding register empty, pair can be accepted |
| bck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| bck_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| sdata | output | 1 | Serial audio data, MSB first |

## Verification
Two events can fall in the same `clk` edge: the handshake accepting a new pair, and the left-slot load that empties the holding register. The bench forces this in master mode. It counts 255 `clk` cycles from a word-select fall, then raises `smp_valid` so that acceptance lands exactly on the next frame's load edge. The scoreboard must then find that pair in the frame that starts at this edge, not one frame later, and `smp_ready` must still read 1 afterwards. A second pair offered while the register is full must wait for the load, then be accepted in the following cycle.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

  // frame timing variants
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } fmt_e;

  localparam int SAMPLE_W_DEF = 24;
  localparam int SLOT_W_DEF   = 32;
  localparam int MCLK_DIV_DEF = 4;
  localparam int SYNC_DEF     = 2;

endpackage

// File: rtl/ser_bclk_gen.sv
module ser_bclk_gen #(
  parameter int DIV    = 4,
  parameter int SLOT_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bck,
  output logic ws,
  output logic tick,
  output logic ws_next
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int SW = $clog2(SLOT_W);

  logic [CW-1:0] cnt, cnt_n;
  logic [SW-1:0] scnt;
  logic          ws_q;
  logic          bck_q;

  // tick marks the clk cycle at whose end the bit clock falls
  assign tick    = en && (cnt == CW'(DIV - 1));
  assign ws_next = (scnt == SW'(SLOT_W - 1)) ? ~ws_q : ws_q;
  assign cnt_n   = tick ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      bck_q <= 1'b0;
      scnt  <= SW'(SLOT_W - 1);
      ws_q  <= 1'b1;
    end else begin
      cnt   <= cnt_n;
      bck_q <= (cnt_n >= CW'(DIV / 2));
      if (tick) begin
        scnt <= (scnt == SW'(SLOT_W - 1)) ? '0 : scnt + 1'b1;
        ws_q <= ws_next;
      end
    end
  end

  assign bck = bck_q;
  assign ws  = ws_q;

  AST_WS_WITH_BCK_FALL: assert property (@(posedge clk) disable iff (rst || !en)
    !$stable(ws_q) |-> $fell(bck_q));  // R3
  AST_BCK_HIGH_TWO: assert property (@(posedge clk) disable iff (rst || !en)
    ((DIV >= 4) && $rose(bck_q)) |=> bck_q);  // R2

endmodule

// File: rtl/ser_bclk_sync.sv
module ser_bclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_i,
  input  logic ws_i,
  output logic tick,
  output logic ws_lvl
);

  logic [STAGES:0]   bsh;
  logic [STAGES-1:0] wsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bsh <= '0;
      wsh <= '1;
    end else begin
      bsh <= {bsh[STAGES-1:0], bck_i};
      wsh <= {wsh[STAGES-2:0], ws_i};
    end
  end

  // falling edge seen at the synchronizer output
  assign tick   = bsh[STAGES] & ~bsh[STAGES-1];
  assign ws_lvl = wsh[STAGES-1];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);  // R8

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_audio_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ws_lvl,
  input  fmt_e              fmt,
  input  logic              valid,
  input  logic [DATA_W-1:0] left,
  input  logic [DATA_W-1:0] right,
  output logic              ready,
  output logic              sdata
);

  localparam int IW = $clog2(SLOT_W);
  localparam int KW = $clog2(DATA_W);

  logic              hold_empty;
  logic [DATA_W-1:0] hold_l, hold_r;
  logic [DATA_W-1:0] cur_l, cur_r;
  logic [DATA_W-1:0] new_l, new_r, use_l, use_r, word;
  logic              ws_prev;
  logic [IW-1:0]     idx, idx_n;
  logic              sd_q, bit_n;
  logic              accept, load;

  assign accept = valid & hold_empty;
  assign load   = tick & ~ws_lvl & ws_prev;

  // held pair, else a pair arriving this cycle, else silence
  assign new_l = !hold_empty ? hold_l : (accept ? left  : '0);
  assign new_r = !hold_empty ? hold_r : (accept ? right : '0);
  assign use_l = load ? new_l : cur_l;
  assign use_r = load ? new_r : cur_r;
  assign word  = ws_lvl ? use_r : use_l;

  assign idx_n = (ws_lvl != ws_prev) ? '0 :
                 (idx == IW'(SLOT_W - 1)) ? idx : idx + 1'b1;

  always_comb begin
    int k;
    bit_n = 1'b0;
    if (fmt == FMT_LJ) k = DATA_W - 1 - int'(idx_n);
    else               k = DATA_W - int'(idx_n);
    if (k >= 0 && k < DATA_W) bit_n = word[KW'(k)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_empty <= 1'b1;
      hold_l     <= '0;
      hold_r     <= '0;
      cur_l      <= '0;
      cur_r      <= '0;
      ws_prev    <= 1'b1;
      idx        <= IW'(SLOT_W - 1);
      sd_q       <= 1'b0;
    end else begin
      if (load) begin
        hold_empty <= 1'b1;
      end else if (accept) begin
        hold_empty <= 1'b0;
        hold_l     <= left;
        hold_r     <= right;
      end
      if (tick) begin
        ws_prev <= ws_lvl;
        idx     <= idx_n;
        sd_q    <= bit_n;
        if (load) begin
          cur_l <= new_l;
          cur_r <= new_r;
        end
      end
    end
  end

  assign ready = hold_empty;
  assign sdata = sd_q;

  AST_SD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sd_q));  // R4
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> hold_empty);  // R9
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!hold_empty && !load) |=> (!hold_empty && $stable(hold_l) && $stable(hold_r)));  // R9

endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
  import ser_audio_pkg::*;
#(
  parameter int DATA_W   = SAMPLE_W_DEF,
  parameter int SLOT_W   = SLOT_W_DEF,
  parameter int MCLK_DIV = MCLK_DIV_DEF,
  parameter int SYNC_N   = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              fmt_sel,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_left,
  input  logic [DATA_W-1:0] smp_right,
  output logic              smp_ready,
  input  logic              bck_in,
  input  logic              ws_in,
  output logic              bck_out,
  output logic              ws_out,
  output logic              sdata
);

  logic m_tick, m_wsn, s_tick, s_ws;
  logic f_tick, f_ws;

  ser_bclk_gen #(.DIV(MCLK_DIV), .SLOT_W(SLOT_W)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .en      (master_mode),
    .bck     (bck_out),
    .ws      (ws_out),
    .tick    (m_tick),
    .ws_next (m_wsn)
  );

  ser_bclk_sync #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .bck_i  (bck_in),
    .ws_i   (ws_in),
    .tick   (s_tick),
    .ws_lvl (s_ws)
  );

  assign f_tick = master_mode ? m_tick : s_tick;
  assign f_ws   = master_mode ? m_wsn  : s_ws;

  ser_frame_tx #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick   (f_tick),
    .ws_lvl (f_ws),
    .fmt    (fmt_e'(fmt_sel)),
    .valid  (smp_valid),
    .left   (smp_left),
    .right  (smp_right),
    .ready  (smp_ready),
    .sdata  (sdata)
  );

endmodule

// File: tb/sim_ser_audio_tx.sv
`timescale 1ns/1ps
module sim_ser_audio_tx;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        master_mode = 1'b1;
  logic        fmt_sel = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_left = '0;
  logic [23:0] smp_right = '0;
  logic        smp_ready;
  logic        bck_in = 1'b1;
  logic        ws_in = 1'b1;
  logic        bck_out, ws_out, sdata;

  ser_audio_tx u0 (
    .clk(clk), .rst(rst), .master_mode(master_mode), .fmt_sel(fmt_sel),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .smp_ready(smp_ready), .bck_in(bck_in), .ws_in(ws_in),
    .bck_out(bck_out), .ws_out(ws_out), .sdata(sdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  typedef struct packed { logic [23:0] l; logic [23:0] r; } pair_t;
  pair_t q[$];
  event ev_left;

  // ---------------- monitor / scoreboard ----------------
  logic pw, pb, rws, psd, pbo;
  int pos, run, r2_bad, r4_bad, slave_pos;
  bit active, seen_edge;
  pair_t exp_cur, exp_nxt;
  logic [64:0] fb;

  task automatic eval_frame();
    string tag;
    int off;
    logic [23:0] gl, gr;
    logic pad_bad;
    tag = !master_mode ? "R8" : (fmt_sel ? "R5" : "R6");
    if (exp_cur.l == 24'd0 && exp_cur.r == 24'd0) tag = {tag, "/R10"};
    off = fmt_sel ? 0 : 1;
    pad_bad = 1'b0;
    for (int i = 0; i < 24; i++) begin
      gl[23-i] = fb[off+i];
      gr[23-i] = fb[off+32+i];
    end
    for (int i = 24; i < 32; i++) pad_bad = pad_bad | fb[off+i] | fb[off+32+i];
    if (!fmt_sel) pad_bad = pad_bad | fb[0];
    chk(gl == exp_cur.l, tag, "left word", 64'(gl), 64'(exp_cur.l));
    chk(gr == exp_cur.r, tag, "right word", 64'(gr), 64'(exp_cur.r));
    chk(!pad_bad, "R7", "padding bits", 64'(pad_bad), 64'd0);
  endtask

  always @(posedge clk) begin
    logic wl, bl;
    #2;
    wl = master_mode ? ws_out : ws_in;
    bl = master_mode ? bck_out : bck_in;
    if (rst) begin
      pw = 1; pb = 0; rws = 1; active = 0; pos = 0; psd = 0; pbo = 0;
      run = 0; seen_edge = 0; exp_cur = '0; exp_nxt = '0;
    end else begin
      // snapshot of what the frame starting now must carry
      if (pw && !wl) begin
        if (q.size() > 0) exp_nxt = q.pop_front();
        else exp_nxt = '0;
        -> ev_left;
      end
      if (master_mode) begin
        if (bck_out != pbo) begin
          if (seen_edge && run != 2) r2_bad++;
          seen_edge = 1; run = 1;
        end else run++;
        if (sdata != psd && !(pbo && !bck_out)) r4_bad++;
      end
      if (!pb && bl) begin
        if (!wl && rws) begin
          if (active) begin
            chk(pos == 64, master_mode ? "R3" : "R8", "frame length", 64'(pos), 64'd64);
            fb[64] = sdata;
            eval_frame();
          end
          active = 1; pos = 0; exp_cur = exp_nxt;
        end
        if (wl && !rws && active)
          chk(pos == 32, master_mode ? "R3" : "R8", "left slot length", 64'(pos), 64'd32);
        if (active && pos <= 64) begin fb[pos] = sdata; pos++; end
        rws = wl;
      end
      pw = wl; pb = bl; psd = sdata; pbo = bck_out;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    smp_valid = 1; smp_left = l; smp_right = r;
    while (!smp_ready) @(negedge clk);
    @(posedge clk); #1;
    q.push_back({l, r});
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic do_reset(input logic m, input logic f);
    @(negedge clk);
    rst = 1; master_mode = m; fmt_sel = f; smp_valid = 0;
    bck_in = 1; ws_in = 1; q.delete();
    repeat (4) @(negedge clk);
    chk(sdata == 0, "R1", "sdata in reset", 64'(sdata), 64'd0);
    chk(smp_ready == 1, "R1", "ready in reset", 64'(smp_ready), 64'd1);
    chk(bck_out == 0, "R1", "bck_out in reset", 64'(bck_out), 64'd0);
    chk(ws_out == 1, "R1", "ws_out in reset", 64'(ws_out), 64'd1);
    rst = 0;
  endtask

  task automatic master_seq();
    r2_bad = 0; r4_bad = 0;
    @(ev_left);
    repeat (10) @(posedge clk);
    send(24'hABCDEF, 24'h123456);
    chk(smp_ready == 0, "R9", "ready after accept", 64'(smp_ready), 64'd0);
    send(24'h800001, 24'h7FFFFE);
    chk(smp_ready == 0, "R9", "ready after waited accept", 64'(smp_ready), 64'd0);
    repeat (3) @(ev_left);
    // R11: acceptance on the load edge itself
    @(ev_left);
    repeat (255) @(posedge clk);
    @(negedge clk);
    smp_valid = 1; smp_left = 24'h5A5A5A; smp_right = 24'hC3C3C3;
    @(posedge clk); #1;
    q.push_back({24'h5A5A5A, 24'hC3C3C3});
    @(negedge clk);
    smp_valid = 0;
    chk(smp_ready == 1, "R11", "ready after bypass", 64'(smp_ready), 64'd1);
    chk(ws_out == 0, "R11", "bypass on left start", 64'(ws_out), 64'd0);
    send(24'hFFFFFF, 24'h000000);
    send(24'h555555, 24'hAAAAAA);
    repeat (4) @(ev_left);
    chk(r2_bad == 0, "R2", "bck half-period violations", 64'(r2_bad), 64'd0);
    chk(r4_bad == 0, "R4", "sdata change off bck fall", 64'(r4_bad), 64'd0);
  endtask

  task automatic slave_frames(input int n);
    for (int f = 0; f < n; f++) begin
      for (int b = 0; b < 64; b++) begin
        @(negedge clk);
        slave_pos = b;
        bck_in = 0;
        if (b == 0) ws_in = 0;
        if (b == 32) ws_in = 1;
        repeat (4) @(negedge clk);
        bck_in = 1;
        repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic slave_seq();
    logic [23:0] dl [4];
    logic [23:0] dr [4];
    dl = '{24'h13579B, 24'hFFFFFF, 24'h800000, 24'h000001};
    dr = '{24'h2468AC, 24'h000000, 24'h7FFFFF, 24'hFEDCBA};
    slave_pos = 63;
    fork
      slave_frames(7);
      begin
        for (int k = 0; k < 4; k++) begin
          wait (slave_pos == 40);
          send(dl[k], dr[k]);
          chk(bck_out == 0 && ws_out == 1, "R8", "master outputs idle",
              64'({bck_out, ws_out}), 64'b01);
          wait (slave_pos == 41);
        end
      end
    join
  endtask

  initial begin
    do_reset(1'b1, 1'b1);   // master, MSB-justified
    master_seq();
    do_reset(1'b1, 1'b0);   // master, I2S
    master_seq();
    do_reset(1'b0, 1'b0);   // slave, I2S
    slave_seq();
    do_reset(1'b0, 1'b1);   // slave, MSB-justified
    slave_seq();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule